// File: doc/BRIEF.md
# Parallel-Bit Execute Packet Dispatcher

This block sits between instruction fetch and decode. It takes in fetch packets of eight 32-bit instruction words and breaks each one into execute packets: groups of words that issue in the same cycle. Membership in a group follows a chain of parallel bits. Bit 0 of each word says whether the word after it joins the same group. The dispatcher issues one group per cycle on an eight-lane output. It keeps track of the next word not yet issued, and it refuses new fetch packets until the words it holds have all been issued.

A mode input decides whether a group may run past the last slot of a fetch packet. With the mode clear, slot 7 always ends a group. A set parallel bit in slot 7 is then reported on an error output and otherwise ignored. With the mode set, a group that reaches slot 7 with its chain still open is held back. It is completed from the start of the next fetch packet, up to a total of eight words.

Top module: `pbit_dispatch`

## Requirements
- R1: A synchronous active-high reset empties the packet buffer and drops any held partial group. In the cycle after reset, `fp_ready` is 1, `ep_valid` is 0 and all lane valid flags are 0. The next accepted packet starts a fresh group.
- R2: Slot k of a fetch packet is `fp_data[32k+31:32k]`, which is the word at byte offset 4k. Bit 0 of each word is its parallel bit.
- R3: A group starts at the oldest unissued slot. It takes in slots in increasing order up to and including the first slot whose parallel bit is 0. One group issues per accepted output handshake.
- R4: The j-th word of a group appears on lane j, which is `ep_lane_data[32j+31:32j]`. With n words in the group, `ep_lane_valid` equals the low n bits set. All flags are 0 when `ep_valid` is 0.
- R5: With `cross_mode` at 0, slot 7 always ends a group and each fetch packet begins a new group.
- R6: With `cross_mode` at 0, `pbit_err` is 1 in exactly those cycles in which a packet is accepted while bit 0 of its slot 7 is 1.
- R7: With `cross_mode` at 1, a group whose chain is still open at slot 7 is held and produces no output. It continues with slot 0 of the next packet.
- R8: A group never holds more than eight words. When the eighth word joins a group, the group closes even if that word's parallel bit is set, and the next word starts a new group.
- R9: A packet with all parallel bits 0 issues as eight single-word groups. A packet with slots 0 to 6 set and slot 7 clear issues as one eight-word group.
- R10: While `ep_valid` is 1 and `ep_ready` is 0, the lane flags and lane data hold unchanged into the next cycle.
- R11: A new fetch packet is accepted only once every group containing words of earlier packets has issued or is issuing in that same cycle. A packet whose chain is held open at slot 7 counts as used up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cross_mode | input | 1 | 1: groups may continue into the next fetch packet |
| fp_valid | input | 1 | Fetch packet offered |
| fp_data | input | 256 | Eight instruction words, slot 0 in the low bits |
| fp_ready | output | 1 | Fetch packet taken when both this and fp_valid are 1 |
| ep_ready | input | 1 | Downstream takes the current group |
| ep_valid | output | 1 | A group is presented |
| ep_lane_valid | output | 8 | Per-lane valid flags, packed from lane 0 |
| ep_lane_data | output | 256 | Per-lane instruction words |
| pbit_err | output | 1 | Slot-7 parallel bit seen in non-crossing mode |

## Verification
The stall-hold and accept-to-output properties assume that `cross_mode` does not change while a packet is buffered. Each of them passes without complaint in any cycle where the mode does change. The bench changes the mode only after every buffered word and expected group has been drained. Within each phase it keeps the mode fixed. It ends every crossing-mode phase with a packet whose slot-7 parallel bit is clear, so no partial group is left behind. Random backpressure on `ep_ready` and random gaps on `fp_valid` exercise the stall and accept timing within those limits.

// File: rtl/pbit_dispatch.sv
module pbit_dispatch #(
  parameter int SLOTS = 8,
  parameter int IW    = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cross_mode,
  input  logic                fp_valid,
  input  logic [SLOTS*IW-1:0] fp_data,
  output logic                fp_ready,
  input  logic                ep_ready,
  output logic                ep_valid,
  output logic [SLOTS-1:0]    ep_lane_valid,
  output logic [SLOTS*IW-1:0] ep_lane_data,
  output logic                pbit_err
);
  localparam int PW = $clog2(SLOTS);
  localparam int CW = $clog2(SLOTS + 1);

  logic [IW-1:0] pkt_w   [SLOTS];
  logic [IW-1:0] carry_w [SLOTS];
  logic [IW-1:0] lane_w  [SLOTS];
  logic          pkt_vld;
  logic [PW-1:0] ptr;
  logic [CW-1:0] carry_n;
  logic [CW-1:0] grp_n;
  logic [PW-1:0] grp_end;
  logic          closed;
  logic          partial, last, issue, accept;

  always_comb begin
    grp_n   = carry_n;
    grp_end = ptr;
    closed  = 1'b0;
    for (int j = 0; j < SLOTS; j++)
      lane_w[j] = (CW'(j) < carry_n) ? carry_w[j] : '0;
    for (int s = 0; s < SLOTS; s++) begin
      if (!closed && s >= int'(ptr) && grp_n < CW'(SLOTS)) begin
        lane_w[grp_n[PW-1:0]] = pkt_w[s];
        grp_n   = grp_n + 1'b1;
        grp_end = PW'(s);
        if (!(pkt_w[s][0] && (cross_mode || s != SLOTS - 1)) || grp_n == CW'(SLOTS))
          closed = 1'b1;
      end
    end
  end

  assign partial  = pkt_vld && !closed;
  assign last     = grp_end == PW'(SLOTS - 1);
  assign ep_valid = pkt_vld && !partial;
  assign issue    = ep_valid && ep_ready;
  assign fp_ready = !pkt_vld || partial || (issue && last);
  assign accept   = fp_valid && fp_ready;
  assign pbit_err = accept && !cross_mode && fp_data[(SLOTS-1)*IW];

  for (genvar j = 0; j < SLOTS; j++) begin : g_lane
    assign ep_lane_valid[j]         = ep_valid && (CW'(j) < grp_n);
    assign ep_lane_data[j*IW +: IW] = lane_w[j];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pkt_vld <= 1'b0;
      ptr     <= '0;
      carry_n <= '0;
    end else begin
      if (partial) begin
        carry_w <= lane_w;
        carry_n <= grp_n;
        pkt_vld <= 1'b0;
      end else if (issue) begin
        carry_n <= '0;
        if (last) pkt_vld <= 1'b0;
        else      ptr     <= grp_end + 1'b1;
      end
      if (accept) begin
        for (int s = 0; s < SLOTS; s++) pkt_w[s] <= fp_data[s*IW +: IW];
        pkt_vld <= 1'b1;
        ptr     <= '0;
      end
    end
  end
endmodule

// File: rtl/pbit_dispatch_chk.sv
module pbit_dispatch_chk #(
  parameter int SLOTS = 8,
  parameter int IW    = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                cross_mode,
  input logic                fp_valid,
  input logic [SLOTS*IW-1:0] fp_data,
  input logic                fp_ready,
  input logic                ep_ready,
  input logic                ep_valid,
  input logic [SLOTS-1:0]    ep_lane_valid,
  input logic [SLOTS*IW-1:0] ep_lane_data,
  input logic                pbit_err
);
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> fp_ready && !ep_valid && ep_lane_valid == '0);

  a_r4_lanes_packed: assert property (@(posedge clk) disable iff (rst)
    ep_valid |-> ep_lane_valid[0] && $onehot0({1'b0, ep_lane_valid} + (SLOTS+1)'(1)));

  a_r4_no_stray_lane: assert property (@(posedge clk) disable iff (rst)
    !ep_valid |-> ep_lane_valid == '0);

  a_r10_stall_hold: assert property (@(posedge clk) disable iff (rst)
    ep_valid && !ep_ready |=> !$stable(cross_mode) ||
      (ep_valid && $stable(ep_lane_valid) && $stable(ep_lane_data)));

  a_r11_no_early_accept: assert property (@(posedge clk) disable iff (rst)
    ep_valid && !ep_ready |-> !fp_ready);

  a_r5_packet_issues: assert property (@(posedge clk) disable iff (rst)
    !cross_mode && fp_valid && fp_ready |=> ep_valid || !$stable(cross_mode));

  a_r6_err_on_accept: assert property (@(posedge clk) disable iff (rst)
    pbit_err |-> fp_valid && fp_ready && !cross_mode);
endmodule

bind pbit_dispatch pbit_dispatch_chk #(.SLOTS(SLOTS), .IW(IW)) chk_i (.*);

// File: tb/pbit_dispatch_tb_top.sv
module pbit_dispatch_tb_top;
  localparam int SLOTS = 8;
  localparam int IW    = 32;
  localparam int W     = SLOTS * IW;

  logic clk = 1'b0, rst = 1'b1, cross_mode = 1'b0;
  logic fp_valid = 1'b0, ep_ready = 1'b0;
  logic [W-1:0] fp_data = '0;
  logic fp_ready, ep_valid, pbit_err;
  logic [SLOTS-1:0] ep_lane_valid;
  logic [W-1:0] ep_lane_data;

  always #5 clk = ~clk;

  pbit_dispatch #(.SLOTS(SLOTS), .IW(IW)) dut_i (.*);

  typedef struct { int n; logic [W-1:0] d; } grp_t;
  grp_t         exp_q[$];
  logic [W-1:0] sendq[$];
  int           cur_n = 0;
  logic [W-1:0] cur_d = '0;
  int           checks = 0, fails = 0;
  string        tag = "R3";
  bit           force_rdy = 0, held = 0;
  logic [SLOTS-1:0] h_lv;
  logic [W-1:0]     h_ld;

  task automatic chk(bit ok, string req, string what, logic [W-1:0] act, logic [W-1:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  function automatic logic [W-1:0] mk(logic [SLOTS-1:0] pb);
    logic [W-1:0] p;
    for (int s = 0; s < SLOTS; s++) p[s*IW +: IW] = {$urandom() % (1 << 30), 1'b0, pb[s]};
    return p;
  endfunction

  function automatic void model(logic [W-1:0] p);
    for (int s = 0; s < SLOTS; s++) begin
      cur_d[cur_n*IW +: IW] = p[s*IW +: IW];
      cur_n++;
      if (!(p[s*IW] && (cross_mode || s != SLOTS-1)) || cur_n == SLOTS) begin
        exp_q.push_back('{cur_n, cur_d});
        cur_n = 0;
        cur_d = '0;
      end
    end
  endfunction

  task automatic step();
    grp_t g;
    logic [W-1:0] m;
    @(negedge clk);
    ep_ready = force_rdy ? 1'b1 : (($urandom() % 4) != 0);
    fp_valid = (sendq.size() > 0) && (($urandom() % 3) != 0);
    fp_data  = (sendq.size() > 0) ? sendq[0] : '0;
    #1;
    if (held)
      chk(ep_valid && ep_lane_valid == h_lv && ep_lane_data == h_ld, "R10", "stalled output held",
          {ep_lane_valid, ep_lane_data[W-SLOTS-1:0]}, {h_lv, h_ld[W-SLOTS-1:0]});
    held = ep_valid && !ep_ready;
    h_lv = ep_lane_valid;
    h_ld = ep_lane_data;
    if (ep_valid && ep_ready) begin
      if (exp_q.size() == 0) chk(0, tag, "unexpected group", W'(ep_lane_valid), '0);
      else begin
        g = exp_q.pop_front();
        m = '0;
        for (int j = 0; j < g.n; j++) m[j*IW +: IW] = '1;
        chk(ep_lane_valid == SLOTS'((1 << g.n) - 1), "R4", "lane valid",
            W'(ep_lane_valid), W'((1 << g.n) - 1));
        chk((ep_lane_data & m) == (g.d & m), tag, "group data", ep_lane_data & m, g.d & m);
      end
    end
    if ((fp_valid && fp_ready) || pbit_err)
      chk(pbit_err == (!cross_mode && fp_valid && fp_ready && fp_data[(SLOTS-1)*IW]), "R6",
          "pbit_err", W'(pbit_err), W'(!cross_mode && fp_data[(SLOTS-1)*IW]));
    if (fp_valid && fp_ready) begin
      chk(exp_q.size() == 0, "R11", "accept with groups pending", W'(exp_q.size()), '0);
      model(sendq.pop_front());
    end
  endtask

  task automatic drain(string t);
    int guard = 0;
    tag = t;
    while ((sendq.size() > 0 || exp_q.size() > 0) && guard < 5000) begin
      step();
      guard++;
    end
    if (guard >= 5000) chk(0, t, "drain timeout", W'(exp_q.size()), '0);
    repeat (2) step();
    chk(!ep_valid && cur_n == 0, t, "idle after drain", W'(ep_valid), '0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; fp_valid = 1'b0;
    @(negedge clk);
    rst = 1'b0; held = 0;
    exp_q.delete(); cur_n = 0; cur_d = '0;
    #1;
    chk(fp_ready && !ep_valid && ep_lane_valid == '0, "R1", "reset state",
        W'({fp_ready, ep_valid, ep_lane_valid}), W'({1'b1, 1'b0, 8'h00}));
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    do_reset();

    force_rdy = 1;
    sendq.push_back(mk(8'h00));
    sendq.push_back(mk(8'h7F));
    drain("R9");
    force_rdy = 0;

    sendq.push_back(mk(8'hFF));
    sendq.push_back(mk(8'h80));
    sendq.push_back(mk(8'h2C));
    drain("R5");

    cross_mode = 1'b1;
    sendq.push_back(mk(8'hE0));
    sendq.push_back(mk(8'h00));
    sendq.push_back(mk(8'hF0));
    sendq.push_back(mk(8'h03));
    drain("R7");

    sendq.push_back(mk(8'hFF));
    sendq.push_back(mk(8'hFF));
    sendq.push_back(mk(8'hF8));
    sendq.push_back(mk(8'hFF));
    sendq.push_back(mk(8'h00));
    drain("R8");

    cross_mode = 1'b0;
    for (int i = 0; i < 40; i++) sendq.push_back(mk(SLOTS'($urandom())));
    drain("R2");

    cross_mode = 1'b1;
    for (int i = 0; i < 40; i++) sendq.push_back(mk(SLOTS'($urandom())));
    sendq.push_back(mk(8'h00));
    drain("R3");

    sendq.push_back(mk(8'h80));
    tag = "R7";
    while (sendq.size() > 0 || exp_q.size() > 0) step();
    repeat (2) step();
    chk(!ep_valid && cur_n == 1, "R7", "slot 7 held open", W'(ep_valid), '0);
    do_reset();
    sendq.push_back(mk(8'h00));
    drain("R1");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(10 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule